// File: doc/BRIEF.md
# Ethernet DMA control/status register bank

This block is the software-visible register bank that sits in front of an Ethernet DMA engine. A host reaches it through a plain 32-bit write port and a combinational read port. Both take a byte address, and the bank decodes the word index from it. The bank holds the following registers:
- the DMA status word and its interrupt enable mask;
- the control word, which carries the receive enable;
- the bus mode word;
- the receive and transmit descriptor list bases, each with its current descriptor pointer.

The transmit and receive engines report events through single-cycle pulses. Each pulse sets its status bits. One level interrupt stays high while any enabled status bit is set.

Software retires status bits by writing ones to the status word. Writing a list base also rewinds the matching current pointer. A write to the transmit poll word stores nothing. Instead it starts a two-state kick machine. The machine leaves `KICK_IDLE` for `KICK_FIRE` on a poll write and raises `tx_kick` for the one cycle it spends there. From `KICK_FIRE` it returns to `KICK_IDLE`, or it stays in `KICK_FIRE` when a second poll write arrives in that cycle. Both transitions are taken on the clock edge that samples the write.

Top module: `dmacsr_top`

## Requirements
- R1: After reset every register reads zero, and `irq` and `tx_kick` are low.
- R2: The word index is the byte address shifted right by two, so address bits 1:0 have no effect on which register is reached.
- R3: A write to the status word (word 0x3C5) clears each status bit that is 1 in the written value and leaves every other bit unchanged.
- R4: `evt_tx_done` sets status bits 0 and 16. `evt_rx_done` sets bits 6 and 16. `evt_rx_nobuf` sets bits 7 and 15. The bits are visible on the read port in the cycle after the pulse.
- R5: An event pulse in the same cycle as a status clear write wins, so its bits are set after that edge.
- R6: `irq` is high exactly when the status word AND the interrupt enable word (word 0x3C7, read/write) is non-zero, evaluated from the register contents after each edge.
- R7: A write to the receive list base (word 0x3C3) also loads the current receive pointer (word 0x3D3). A write to the transmit list base (word 0x3C4) also loads the current transmit pointer (word 0x3D2). Both current pointers can also be written directly.
- R8: A write to the bus mode word (word 0x3C0) stores the value with bit 0 forced to zero.
- R9: Word 8 always reads 0x00001012, and writes to it have no effect.
- R10: A write to the transmit poll word (word 0x3C1) stores nothing, so the word reads zero. `tx_kick` is high for exactly the cycle after each such write.
- R11: `rx_enable` follows bit 1 of the control word (word 0x3C6, read/write).
- R12: Words outside the map read zero, and writes to them change no register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one cycle |
| addr | input | ADDR_W (12) | Byte address for both read and write |
| wr_data | input | DATA_W (32) | Write data |
| rd_data | output | DATA_W (32) | Combinational read data for `addr` |
| evt_tx_done | input | 1 | Transmit frame complete pulse |
| evt_rx_done | input | 1 | Receive frame complete pulse |
| evt_rx_nobuf | input | 1 | Receive descriptor unavailable pulse |
| irq | output | 1 | Level interrupt |
| tx_kick | output | 1 | One-cycle start strobe to the transmit engine |
| rx_enable | output | 1 | Receive enable from the control word |

## Verification
The bench compares every port against a behavioural model of the bank on every cycle. The status word is tried in several patterns:
- Single events under a full enable mask and under partial enable masks, which shows that the interrupt depends on the mask as well as on the status bits.
- Clears that remove only one of the two bits an event sets, which shows that the clear is per bit and not a wipe of the whole word.
- Events that coincide with a clear of the same bits, which shows the event-over-clear priority.

The remaining patterns are:
- Base and current pointer writes in alternating order, which shows whether a base write rewinds its pointer.
- Single and back-to-back poll writes, which show the pulse width and that the kick machine stays in `KICK_FIRE` across a second write.
- Writes to the ident word, to unmapped words and to addresses with their low bits set, which show that these writes change nothing and that the low address bits are ignored.

// File: rtl/dmacsr_pkg.sv
package dmacsr_pkg;

    // Word indices (byte address >> 2)
    localparam int unsigned W_IDENT   = 'h008;
    localparam int unsigned W_BUSMODE = 'h3C0;
    localparam int unsigned W_TXPOLL  = 'h3C1;
    localparam int unsigned W_RXBASE  = 'h3C3;
    localparam int unsigned W_TXBASE  = 'h3C4;
    localparam int unsigned W_STATUS  = 'h3C5;
    localparam int unsigned W_CONTROL = 'h3C6;
    localparam int unsigned W_INTEN   = 'h3C7;
    localparam int unsigned W_CURTX   = 'h3D2;
    localparam int unsigned W_CURRX   = 'h3D3;

    localparam logic [31:0] IDENT_VALUE = 32'h0000_1012;

    // Status bit positions
    localparam int unsigned ST_TXDONE  = 0;
    localparam int unsigned ST_RXDONE  = 6;
    localparam int unsigned ST_RXNOBUF = 7;
    localparam int unsigned ST_ABNORM  = 15;
    localparam int unsigned ST_NORMAL  = 16;

    localparam int unsigned CTL_RXEN   = 1;

    localparam int unsigned NUM_LISTS  = 2;
    localparam int unsigned LIST_RX    = 0;
    localparam int unsigned LIST_TX    = 1;

    typedef enum logic {
        KICK_IDLE = 1'b0,
        KICK_FIRE = 1'b1
    } kick_state_e;

endpackage

// File: rtl/dmacsr_status.sv
module dmacsr_status #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_en,
    input  logic [DATA_W-1:0] clr_mask,
    input  logic [DATA_W-1:0] set_mask,
    output logic [DATA_W-1:0] stat_q
);

    logic [DATA_W-1:0] stat_d;

    always_comb begin
        stat_d = stat_q;
        if (clr_en) begin
            stat_d = stat_d & ~clr_mask;
        end
        stat_d = stat_d | set_mask;   // events win over the clear
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= stat_d;
        end
    end

    // R3
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && set_mask == '0) |=> ((stat_q & $past(clr_mask)) == '0));

    // R5
    evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_mask != '0) |=> ((stat_q & $past(set_mask)) == $past(set_mask)));

    // R4
    sticky_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_en |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

endmodule

// File: rtl/dmacsr_ptrpair.sv
module dmacsr_ptrpair #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_we,
    input  logic              cur_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] base_q,
    output logic [DATA_W-1:0] cur_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cur_q  <= '0;
        end else begin
            if (base_we) begin
                base_q <= wdata;
                cur_q  <= wdata;
            end else if (cur_we) begin
                cur_q  <= wdata;
            end
        end
    end

    // R7
    base_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        base_we |=> (cur_q == $past(wdata) && base_q == $past(wdata)));

endmodule

// File: rtl/dmacsr_kick.sv
module dmacsr_kick
    import dmacsr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic poll_wr,
    output logic tx_kick
);

    kick_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            KICK_IDLE: if (poll_wr)  state_d = KICK_FIRE;
            KICK_FIRE: if (!poll_wr) state_d = KICK_IDLE;
            default:                 state_d = KICK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= KICK_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        tx_kick = (state_q == KICK_FIRE);
    end

    // R10
    kick_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        poll_wr |=> tx_kick);

    // R10
    kick_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !poll_wr |=> !tx_kick);

endmodule

// File: rtl/dmacsr_top.sv
module dmacsr_top
    import dmacsr_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              evt_tx_done,
    input  logic              evt_rx_done,
    input  logic              evt_rx_nobuf,
    output logic              irq,
    output logic              tx_kick,
    output logic              rx_enable
);

    localparam int unsigned WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    logic [DATA_W-1:0] busmode_q, control_q, inten_q, stat_q, set_mask;
    logic [DATA_W-1:0] base_q [NUM_LISTS];
    logic [DATA_W-1:0] cur_q  [NUM_LISTS];
    logic              hit_busmode, hit_poll, hit_status, hit_control, hit_inten;
    logic [NUM_LISTS-1:0] hit_base, hit_cur;

    assign word = addr[ADDR_W-1:2];

    always_comb begin
        hit_busmode = wr_en && (word == WORD_W'(W_BUSMODE));
        hit_poll    = wr_en && (word == WORD_W'(W_TXPOLL));
        hit_status  = wr_en && (word == WORD_W'(W_STATUS));
        hit_control = wr_en && (word == WORD_W'(W_CONTROL));
        hit_inten   = wr_en && (word == WORD_W'(W_INTEN));
        hit_base[LIST_RX] = wr_en && (word == WORD_W'(W_RXBASE));
        hit_base[LIST_TX] = wr_en && (word == WORD_W'(W_TXBASE));
        hit_cur[LIST_RX]  = wr_en && (word == WORD_W'(W_CURRX));
        hit_cur[LIST_TX]  = wr_en && (word == WORD_W'(W_CURTX));
    end

    always_comb begin
        set_mask = '0;
        if (evt_tx_done) begin
            set_mask[ST_TXDONE] = 1'b1;
            set_mask[ST_NORMAL] = 1'b1;
        end
        if (evt_rx_done) begin
            set_mask[ST_RXDONE] = 1'b1;
            set_mask[ST_NORMAL] = 1'b1;
        end
        if (evt_rx_nobuf) begin
            set_mask[ST_RXNOBUF] = 1'b1;
            set_mask[ST_ABNORM]  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busmode_q <= '0;
            control_q <= '0;
            inten_q   <= '0;
        end else begin
            if (hit_busmode) busmode_q <= {wr_data[DATA_W-1:1], 1'b0};
            if (hit_control) control_q <= wr_data;
            if (hit_inten)   inten_q   <= wr_data;
        end
    end

    dmacsr_status #(.DATA_W(DATA_W)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_en   (hit_status),
        .clr_mask (wr_data),
        .set_mask (set_mask),
        .stat_q   (stat_q)
    );

    for (genvar g = 0; g < NUM_LISTS; g++) begin : g_list
        dmacsr_ptrpair #(.DATA_W(DATA_W)) u_ptr (
            .clk     (clk),
            .rst_n   (rst_n),
            .base_we (hit_base[g]),
            .cur_we  (hit_cur[g]),
            .wdata   (wr_data),
            .base_q  (base_q[g]),
            .cur_q   (cur_q[g])
        );
    end

    dmacsr_kick u_kick (
        .clk     (clk),
        .rst_n   (rst_n),
        .poll_wr (hit_poll),
        .tx_kick (tx_kick)
    );

    always_comb begin
        rd_data = '0;
        case (word)
            WORD_W'(W_IDENT):   rd_data = DATA_W'(IDENT_VALUE);
            WORD_W'(W_BUSMODE): rd_data = busmode_q;
            WORD_W'(W_RXBASE):  rd_data = base_q[LIST_RX];
            WORD_W'(W_TXBASE):  rd_data = base_q[LIST_TX];
            WORD_W'(W_STATUS):  rd_data = stat_q;
            WORD_W'(W_CONTROL): rd_data = control_q;
            WORD_W'(W_INTEN):   rd_data = inten_q;
            WORD_W'(W_CURRX):   rd_data = cur_q[LIST_RX];
            WORD_W'(W_CURTX):   rd_data = cur_q[LIST_TX];
            default:            rd_data = '0;
        endcase
    end

    assign irq       = |(stat_q & inten_q);
    assign rx_enable = control_q[CTL_RXEN];

    // R8
    busmode_bit0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_busmode |=> (busmode_q == ($past(wr_data) & ~DATA_W'(1))));

    // R11
    rxen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_control |=> $stable(rx_enable));

endmodule

// File: tb/tb_dmacsr_top.sv
module tb_dmacsr_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        evt_tx_done = 1'b0, evt_rx_done = 1'b0, evt_rx_nobuf = 1'b0;
    logic        irq, tx_kick, rx_enable;

    int checks = 0;
    int errors = 0;

    // behavioural model state
    logic [31:0] m_stat, m_en, m_ctl, m_bm, m_rxb, m_txb, m_crx, m_ctx;
    logic        m_kick;

    dmacsr_top dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data),
        .evt_tx_done(evt_tx_done), .evt_rx_done(evt_rx_done),
        .evt_rx_nobuf(evt_rx_nobuf),
        .irq(irq), .tx_kick(tx_kick), .rx_enable(rx_enable)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] m_read(input logic [11:0] a);
        case (a[11:2])
            10'h008: return 32'h0000_1012;
            10'h3C0: return m_bm;
            10'h3C3: return m_rxb;
            10'h3C4: return m_txb;
            10'h3C5: return m_stat;
            10'h3C6: return m_ctl;
            10'h3C7: return m_en;
            10'h3D2: return m_ctx;
            10'h3D3: return m_crx;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string rd_req(input logic [11:0] a);
        case (a[11:2])
            10'h008: return "R9";
            10'h3C0: return "R8";
            10'h3C1: return "R10";
            10'h3C3, 10'h3C4, 10'h3D2, 10'h3D3: return "R7";
            10'h3C5: return "R3";
            10'h3C6: return "R11";
            10'h3C7: return "R6";
            default: return "R12";
        endcase
    endfunction

    task automatic model_update(input logic we, input logic [11:0] a,
                                input logic [31:0] d, input logic [2:0] ev);
        m_kick = 1'b0;
        if (we) begin
            case (a[11:2])
                10'h3C0: m_bm = d & 32'hFFFF_FFFE;
                10'h3C1: m_kick = 1'b1;
                10'h3C3: begin m_rxb = d; m_crx = d; end
                10'h3C4: begin m_txb = d; m_ctx = d; end
                10'h3C5: m_stat = m_stat & ~d;
                10'h3C6: m_ctl = d;
                10'h3C7: m_en = d;
                10'h3D2: m_ctx = d;
                10'h3D3: m_crx = d;
                default: ;
            endcase
        end
        if (ev[0]) m_stat = m_stat | 32'h0001_0001;
        if (ev[1]) m_stat = m_stat | 32'h0001_0040;
        if (ev[2]) m_stat = m_stat | 32'h0000_8080;
    endtask

    task automatic check1(input string ph, input string req, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL [%s] %s %s actual=%h expected=%h", ph, req, what, act, exp);
        end
    endtask

    task automatic compare(input string ph);
        check1(ph, rd_req(addr), "rd_data", rd_data, m_read(addr));
        check1(ph, "R6", "irq", {31'h0, irq}, {31'h0, |(m_stat & m_en)});
        check1(ph, "R10", "tx_kick", {31'h0, tx_kick}, {31'h0, m_kick});
        check1(ph, "R11", "rx_enable", {31'h0, rx_enable}, {31'h0, m_ctl[1]});
    endtask

    task automatic step(input logic we, input logic [11:0] a, input logic [31:0] d,
                        input logic [2:0] ev, input string ph);
        wr_en = we; addr = a; wr_data = d;
        evt_tx_done = ev[0]; evt_rx_done = ev[1]; evt_rx_nobuf = ev[2];
        @(posedge clk);
        model_update(we, a, d, ev);
        @(negedge clk);
        compare(ph);
        wr_en = 1'b0;
        evt_tx_done = 1'b0; evt_rx_done = 1'b0; evt_rx_nobuf = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input string ph);
        step(1'b1, a, d, 3'b000, ph);
    endtask

    task automatic rd(input logic [11:0] a, input string ph);
        step(1'b0, a, 32'h0, 3'b000, ph);
    endtask

    task automatic scan(input string ph);
        logic [11:0] list [11];
        list = '{12'h020, 12'hF00, 12'hF04, 12'hF0C, 12'hF10, 12'hF14,
                 12'hF18, 12'hF1C, 12'hF48, 12'hF4C, 12'hF08};
        foreach (list[i]) rd(list[i], ph);
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog expired R1 actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        m_stat = '0; m_en = '0; m_ctl = '0; m_bm = '0;
        m_rxb = '0; m_txb = '0; m_crx = '0; m_ctx = '0; m_kick = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare("R1 reset");
        scan("R1 reset scan");

        // events and interrupt masking
        wr(12'hF1C, 32'hFFFF_FFFF, "R6 enable all");
        step(1'b0, 12'hF14, 0, 3'b001, "R4 tx done");
        rd(12'hF14, "R4 readback");
        wr(12'hF14, 32'h0000_0001, "R3 partial clear");
        wr(12'hF14, 32'h0001_0000, "R3 clear normal");
        step(1'b0, 12'hF14, 0, 3'b010, "R4 rx done");
        step(1'b0, 12'hF14, 0, 3'b100, "R4 rx nobuf");
        wr(12'hF1C, 32'h0000_8000, "R6 mask abnormal only");
        wr(12'hF14, 32'h0000_8000, "R6 irq drops");
        wr(12'hF1C, 32'h0000_0080, "R6 mask nobuf only");
        step(1'b0, 12'hF14, 0, 3'b011, "R6 masked events");
        step(1'b0, 12'hF14, 0, 3'b100, "R6 unmasked event");

        // event versus clear
        step(1'b1, 12'hF14, 32'hFFFF_FFFF, 3'b001, "R5 event beats clear");
        step(1'b1, 12'hF14, 32'h0001_0040, 3'b110, "R5 mixed");
        wr(12'hF14, 32'hFFFF_FFFF, "R3 clear all");

        // list pointers
        wr(12'hF0C, 32'h1000_0000, "R7 rx base");
        wr(12'hF4C, 32'h1000_0020, "R7 cur rx direct");
        wr(12'hF10, 32'h2000_0000, "R7 tx base");
        wr(12'hF48, 32'h2000_0040, "R7 cur tx direct");
        scan("R7 scan");
        wr(12'hF0C, 32'h3000_0000, "R7 rx base rewinds");
        wr(12'hF10, 32'h4000_0000, "R7 tx base rewinds");
        scan("R7 scan 2");

        // bus mode, ident, poll
        wr(12'hF00, 32'hFFFF_FFFF, "R8 busmode");
        rd(12'hF00, "R8 readback");
        wr(12'h020, 32'hDEAD_BEEF, "R9 ident write");
        rd(12'h023, "R9 ident low bits");
        wr(12'hF04, 32'hFFFF_FFFF, "R10 poll");
        rd(12'hF04, "R10 poll idle");
        wr(12'hF04, 32'h1, "R10 poll a");
        wr(12'hF04, 32'h1, "R10 poll b");
        rd(12'hF04, "R10 poll end");

        // control
        wr(12'hF18, 32'h0000_0002, "R11 rx on");
        wr(12'hF18, 32'hFFFF_FFFD, "R11 rx off");
        wr(12'hF18, 32'h0000_2002, "R11 rx on again");

        // unmapped and address low bits
        wr(12'hF08, 32'hFFFF_FFFF, "R12 unmapped 3C2");
        wr(12'hF20, 32'hFFFF_FFFF, "R12 unmapped 3C8");
        wr(12'h000, 32'hFFFF_FFFF, "R12 unmapped 000");
        rd(12'hF08, "R12 read 3C2");
        wr(12'hF1F, 32'h0000_FFFF, "R2 inten low bits 11");
        wr(12'hF0E, 32'h5555_0000, "R2 rx base low bits 10");
        step(1'b1, 12'hF15, 32'h0000_0001, 3'b000, "R2 status low bits 01");
        step(1'b0, 12'hF16, 0, 3'b111, "R2 all events");
        scan("R12 final scan");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule